// File: doc/BRIEF.md
# Packed BCD Add/Subtract Unit

This block does the decimal-mode arithmetic of an 8-bit ALU. It takes an accumulator byte and an operand byte, each holding two packed BCD digits, plus a carry-in and an operation select. It returns a packed BCD result and four flags: carry, zero, negative and overflow. The digit correction is done one nibble at a time, in the style of classic 8-bit processors.

In add mode the flags are taken at fixed points inside the correction sequence, not from the final value. This is done on purpose, so that software relying on those quirks sees the same flags. In subtract mode the negative and zero flags come from the final byte. Two combinational cores, one for add and one for subtract, feed a single output register, so results appear one clock after the inputs. Digits above 9 go through the same steps unchanged, and no error is raised for them.

Top module: `bcd_addsub`

## Requirements
- R1: Add, low digit: s = A[3:0]+M[3:0]+C. If s > 9, then s+6 is kept modulo 16 and one is carried into the high digit.
- R2: Add, high digit: h = A[7:4]+M[7:4]+(low carry). If h > 9, h+6 is formed. carry_o is 1 exactly when that adjusted value exceeds 15. For valid BCD inputs, carry_o = 1 exactly when the decimal sum A+M+C is 100 or more.
- R3: Add, zero flag: zero_o = 1 exactly when the plain binary sum (A+M+C) mod 256 is 0, whatever the decimal result is. Example: 0x99+0x01 gives result 0x00 with zero_o = 0.
- R4: Add, negative flag: neg_o is bit 3 of h (from R2), taken before the +6 adjust. Overflow: ovf_o = NOT(A[7] xor M[7]) AND (A[7] xor neg_o).
- R5: Subtract, low digit: l = A[3:0]−M[3:0]−1+C. If l < 0, 10 is added to l and one is borrowed from the high digit.
- R6: Subtract, high digit: g = A[7:4]−M[7:4]−(low borrow). If g < 0, 10 is added and carry_o = 0. Otherwise carry_o = 1.
- R7: Subtract flags: neg_o = result[7] and zero_o = (result == 0). ovf_o = (A[7] xor M[7]) AND (A[7] xor result[7]).
- R8: The result is {high digit[3:0], low digit[3:0]}. Digits above 9 are processed by the same steps with no error indication. With valid BCD inputs, both result digits are at most 9.
- R9: sub_i = 1 selects subtract and sub_i = 0 selects add. Result and flags are registered and show the inputs present at the previous rising clock edge. An active-low asynchronous reset forces result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Accumulator, packed BCD |
| m_i | input | 8 | Operand, packed BCD |
| carry_i | input | 1 | Carry-in (for subtract, 1 means no borrow) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| res_o | output | 8 | Packed BCD result, registered |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The sweep covers every valid digit pair in both modes with both carry-in values, plus a band of invalid digits. The corner cases the bench targets are:
- 99+01. A design that took zero from the corrected byte would raise zero here.
- 50+50. A design that took negative after the high adjust would drop negative and overflow here.
- 00−01 with carry-in 1. A low-digit borrow that is not passed on leaves 0x09 instead of 0x99 and keeps carry set.
- A reset asserted mid-run. A synchronous reset would leave stale flags visible until the next edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIG_W  = 4;
  localparam int BYTE_W = 2 * DIG_W;
  localparam int SDIG_W = DIG_W + 1;
  localparam int HIX_W  = DIG_W + 2;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  function automatic logic is_bcd(input logic [BYTE_W-1:0] x);
    return (x[BYTE_W-1:DIG_W] <= 4'd9) && (x[DIG_W-1:0] <= 4'd9);
  endfunction

  function automatic int dec_val(input logic [BYTE_W-1:0] x);
    return int'(x[BYTE_W-1:DIG_W]) * 10 + int'(x[DIG_W-1:0]);
  endfunction
endpackage

// File: rtl/bcd_add_core.sv
module bcd_add_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] m_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] res_o,
  output flags_t            flags_o
);
  logic [HIX_W-1:0]  lo_sum, hi_sum, hi_adj;
  logic              lo_big, hi_big;
  logic [DIG_W-1:0]  lo_dig, hi_dig;
  logic [BYTE_W-1:0] bin_sum;

  always_comb begin
    lo_sum  = HIX_W'(a_i[DIG_W-1:0]) + HIX_W'(m_i[DIG_W-1:0]) + HIX_W'(carry_i);
    lo_big  = lo_sum > HIX_W'(9);
    lo_dig  = lo_sum[DIG_W-1:0] + (lo_big ? 4'd6 : 4'd0);
    hi_sum  = HIX_W'(a_i[BYTE_W-1:DIG_W]) + HIX_W'(m_i[BYTE_W-1:DIG_W]) + HIX_W'(lo_big);
    hi_big  = hi_sum > HIX_W'(9);
    hi_adj  = hi_sum + (hi_big ? HIX_W'(6) : HIX_W'(0));
    hi_dig  = hi_adj[DIG_W-1:0];
    // zero is taken from the uncorrected binary sum
    bin_sum = a_i + m_i + BYTE_W'(carry_i);
    flags_o.z = (bin_sum == '0);
    // negative/overflow sampled before the high-digit adjust
    flags_o.n = hi_sum[DIG_W-1];
    flags_o.v = ~(a_i[BYTE_W-1] ^ m_i[BYTE_W-1]) & (a_i[BYTE_W-1] ^ hi_sum[DIG_W-1]);
    flags_o.c = hi_adj > HIX_W'(15);
    res_o     = {hi_dig, lo_dig};
  end
endmodule

// File: rtl/bcd_sub_core.sv
module bcd_sub_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] m_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] res_o,
  output flags_t            flags_o
);
  // range -16..15 fits a signed digit plus sign bit
  logic [SDIG_W-1:0] lo_raw, hi_raw;
  logic              lo_neg, hi_neg;
  logic [DIG_W-1:0]  lo_dig, hi_dig;

  always_comb begin
    lo_raw = SDIG_W'(a_i[DIG_W-1:0]) - SDIG_W'(m_i[DIG_W-1:0]) - SDIG_W'(1) + SDIG_W'(carry_i);
    lo_neg = lo_raw[SDIG_W-1];
    lo_dig = lo_raw[DIG_W-1:0] + (lo_neg ? 4'd10 : 4'd0);
    hi_raw = SDIG_W'(a_i[BYTE_W-1:DIG_W]) - SDIG_W'(m_i[BYTE_W-1:DIG_W]) - SDIG_W'(lo_neg);
    hi_neg = hi_raw[SDIG_W-1];
    hi_dig = hi_raw[DIG_W-1:0] + (hi_neg ? 4'd10 : 4'd0);
    res_o     = {hi_dig, lo_dig};
    flags_o.c = ~hi_neg;
    flags_o.n = hi_dig[DIG_W-1];
    flags_o.z = ({hi_dig, lo_dig} == '0);
    flags_o.v = (a_i[BYTE_W-1] ^ m_i[BYTE_W-1]) & (a_i[BYTE_W-1] ^ hi_dig[DIG_W-1]);
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] m_i,
  input  logic              carry_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              ovf_o
);
  logic [BYTE_W-1:0] add_res, sub_res, res_d, res_q;
  flags_t            add_flg, sub_flg, flg_d, flg_q;

  bcd_add_core u_add (
    .a_i(a_i), .m_i(m_i), .carry_i(carry_i), .res_o(add_res), .flags_o(add_flg)
  );

  bcd_sub_core u_sub (
    .a_i(a_i), .m_i(m_i), .carry_i(carry_i), .res_o(sub_res), .flags_o(sub_flg)
  );

  assign res_d = sub_i ? sub_res : add_res;
  assign flg_d = sub_i ? sub_flg : add_flg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign res_o   = res_q;
  assign carry_o = flg_q.c;
  assign zero_o  = flg_q.z;
  assign neg_o   = flg_q.n;
  assign ovf_o   = flg_q.v;

  // add carry matches decimal sum for valid digits
  p_add_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sub_i && is_bcd(a_i) && is_bcd(m_i)) |->
      (add_flg.c == (dec_val(a_i) + dec_val(m_i) + int'(carry_i) >= 100)));

  // add overflow only when operand signs agree
  p_add_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sub_i && add_flg.v) |-> (a_i[BYTE_W-1] == m_i[BYTE_W-1]));

  // subtract carry means no decimal borrow
  p_sub_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && is_bcd(a_i) && is_bcd(m_i)) |->
      (sub_flg.c == (dec_val(a_i) >= dec_val(m_i) + 1 - int'(carry_i))));

  // subtract overflow only when operand signs differ
  p_sub_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && sub_flg.v) |-> (a_i[BYTE_W-1] != m_i[BYTE_W-1]));

  // valid digits in, valid digits out
  p_digits_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_bcd(a_i) && is_bcd(m_i)) |-> is_bcd(res_d));

  // registered outputs follow the selected core by one cycle
  p_reg_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (res_o == $past(sub_i ? sub_res : add_res)));
endmodule

// File: tb/bcd_addsub_test.sv
module bcd_addsub_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, m_i = '0;
  logic       carry_i = 1'b0, sub_i = 1'b0;
  logic [7:0] res_o;
  logic       carry_o, zero_o, neg_o, ovf_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bcd_addsub uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .m_i(m_i), .carry_i(carry_i),
    .sub_i(sub_i), .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o),
    .neg_o(neg_o), .ovf_o(ovf_o)
  );

  // {sub, cin, a, m, res, c, z, n, v}
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h09, 8'h01, 8'h10, 4'b0000},
    {1'b0, 1'b0, 8'h99, 8'h01, 8'h00, 4'b1010},
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0100},
    {1'b0, 1'b0, 8'h50, 8'h50, 8'h00, 4'b1011},
    {1'b0, 1'b1, 8'h45, 8'h45, 8'h91, 4'b0011},
    {1'b1, 1'b1, 8'h50, 8'h01, 8'h49, 4'b1000},
    {1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 4'b0010},
    {1'b1, 1'b1, 8'h42, 8'h42, 8'h00, 4'b1100},
    {1'b1, 1'b0, 8'h42, 8'h42, 8'h99, 4'b0010},
    {1'b1, 1'b1, 8'h10, 8'h90, 8'h20, 4'b0000},
    {1'b1, 1'b1, 8'h80, 8'h10, 8'h70, 4'b1001},
    {1'b0, 1'b0, 8'h0F, 8'h0F, 8'h14, 4'b0000}
  };
  localparam string TAG [NV] = '{"R1", "R3", "R3", "R4", "R4", "R5",
                                  "R5", "R7", "R6", "R6", "R7", "R8"};

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // returns {res, c, z, n, v}
  function automatic logic [11:0] model(input bit sub, input bit c, input int a, input int m);
    int lo, hi, res;
    bit fc, fz, fn, fv;
    bit a7 = a[7], m7 = m[7];
    if (!sub) begin
      lo = (a & 15) + (m & 15) + c;
      hi = (a >> 4) + (m >> 4);
      fz = ((a + m + c) & 255) == 0;
      if (lo > 9) begin lo += 6; hi += 1; end
      fn = hi[3];
      fv = !(a7 ^ m7) && (a7 ^ fn);
      if (hi > 9) hi += 6;
      fc = hi > 15;
      res = ((hi & 15) << 4) | (lo & 15);
    end else begin
      lo = (a & 15) - (m & 15) - 1 + c;
      hi = (a >> 4) - (m >> 4);
      if (lo < 0) begin lo += 10; hi -= 1; end
      fc = 1;
      if (hi < 0) begin hi += 10; fc = 0; end
      res = ((hi & 15) << 4) | (lo & 15);
      fn = res[7];
      fz = res == 0;
      fv = (a7 ^ m7) && (a7 ^ fn);
    end
    return {res[7:0], fc, fz, fn, fv};
  endfunction

  task automatic apply(input bit sub, input bit c, input logic [7:0] a, input logic [7:0] m);
    @(negedge clk_i);
    sub_i = sub; carry_i = c; a_i = a; m_i = m;
    @(posedge clk_i);
    #1;
  endtask

  task automatic sweep_one(input bit sub, input bit c, input int a, input int m);
    logic [11:0] e;
    e = model(sub, c, a, m);
    apply(sub, c, 8'(a), 8'(m));
    check("R8 result", res_o, e[11:4]);
    if (!sub) begin
      check("R2 carry", carry_o, e[3]);
      check("R3 zero", zero_o, e[2]);
      check("R4 n/v", {neg_o, ovf_o}, e[1:0]);
    end else begin
      check("R6 carry", carry_o, e[3]);
      check("R7 flags", {zero_o, neg_o, ovf_o}, e[2:0]);
    end
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #9;
    check("R9 reset result", res_o, 0);
    check("R9 reset flags", {carry_o, zero_o, neg_o, ovf_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][29], VEC[i][28], VEC[i][27:20], VEC[i][19:12]);
      check({TAG[i], " table result"}, res_o, VEC[i][11:4]);
      check({TAG[i], " table flags"}, {carry_o, zero_o, neg_o, ovf_o}, VEC[i][3:0]);
    end

    // R1 R5: exhaustive valid BCD pairs, both modes and carries
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 100; a++)
          for (int m = 0; m < 100; m++)
            sweep_one(s[0], c[0], ((a / 10) << 4) | (a % 10), ((m / 10) << 4) | (m % 10));

    // R8: invalid digits pass through the same steps
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int m = 0; m < 256; m += 17)
          sweep_one(s[0], a[0], a, m);

    // R9: output holds old value until the edge
    apply(1'b0, 1'b0, 8'h12, 8'h34);
    @(negedge clk_i);
    sub_i = 1'b1; a_i = 8'h00; m_i = 8'h01; carry_i = 1'b1;
    #1;
    check("R9 held before edge", res_o, 8'h46);
    @(posedge clk_i); #1;
    check("R9 updated after edge", res_o, 8'h99);

    // R9: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #0.5;
    check("R9 async reset result", res_o, 0);
    check("R9 async reset flags", {carry_o, zero_o, neg_o, ovf_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule